// File: doc/BRIEF.md
# Vector Memory Fault-Deferral Sequencer

This block walks the elements of one vector load or store and issues a single memory request per active element, in ascending element order. Each request is answered by a translation response that says whether that element's address faulted. A fault does not stop the walk: the element is flagged, its virtual address is stored, and the walk moves on. Only when every active element has been attempted does the block raise a single exception, so that a handler can resolve all faulting pages in one visit rather than trapping once per page.

A pending mask records which elements still have to be performed. A fresh instruction loads it with ones for every active element. A successful access clears its bit, and a faulted element keeps its bit. After the handler has fixed the faults, the instruction is restarted with the existing mask kept, so elements that already completed are never performed twice. The handler reads the per-element fault addresses through a read port that only supervisor or machine privilege may use.

Top module: `vfd_seq_top`

## Requirements
- R1: A translation response with the fault bit set does not raise `exc_o` at once. It sets that element's bit in `fault_flags_o`, and the walk goes on to the next element.
- R2: `exc_o` pulses for exactly one cycle, and only after every pending active element has received its response. It pulses only if at least one fault flag is set. A pass that sees no fault never raises `exc_o`.
- R3: A fresh start (`restart_i`=0) sets `pending_o` bit i for every i below the active length. Only elements whose pending bit is set get a request. A fault-free response clears that element's bit, and a faulting response leaves it set.
- R4: A start with `restart_i`=1 keeps the existing pending mask. Elements completed in an earlier pass get no request.
- R5: The fault-address entry of each element that faulted in the current pass holds the request address of that element. Every other entry reads as zero. All entries clear when a pass is accepted.
- R6: A read with `rd_priv_i` = 2'b01 (supervisor) or 2'b11 (machine) returns entry `rd_idx_i` on `rd_data_o` in the cycle after `rd_en_i`, with `rd_err_o` low. A read with 2'b00 (user) returns zero data, and `rd_err_o` is high for that one cycle only.
- R7: The request address of element i is `base_i + 4*i` in unit-stride mode (`indexed_i`=0). In indexed mode it is `base_i` plus the index entry held in bits [32*i +: 32] of `index_i`. Requests go out in ascending element order. At most one request is outstanding, and the next one waits for the current response.
- R8: Elements at or beyond the active length `len_i` (1 to 8) are treated as complete. They get no request, and their pending bits are clear.
- R9: A pass that ends with no fault flag pulses `done_o` for one cycle. It leaves `pending_o` all zero and every fault-address entry zero.
- R10: A start raised while a pass is in progress is ignored. The pass keeps its original configuration, and no element gets a second request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a pass (taken only when idle) |
| restart_i | input | 1 | Keep the existing pending mask on this start |
| indexed_i | input | 1 | 1 = indexed addressing, 0 = unit stride |
| store_i | input | 1 | 1 = store, 0 = load; forwarded with each request |
| len_i | input | 4 | Active element count, 1 to 8 |
| base_i | input | 32 | Base virtual address |
| index_i | input | 256 | Index vector, element i in bits [32*i +: 32] |
| mreq_valid_o | output | 1 | Memory request for one element |
| mreq_store_o | output | 1 | Request is a store |
| mreq_elem_o | output | 3 | Element number of the request |
| mreq_addr_o | output | 32 | Virtual address of the request |
| xlat_valid_i | input | 1 | Translation response valid |
| xlat_fault_i | input | 1 | Translation response reports a fault |
| rd_en_i | input | 1 | Fault-address read strobe |
| rd_priv_i | input | 2 | Privilege of the reader (00 user, 01 supervisor, 11 machine) |
| rd_idx_i | input | 3 | Element entry to read |
| rd_data_o | output | 32 | Read data, valid the cycle after the strobe |
| rd_err_o | output | 1 | Read rejected for lack of privilege |
| busy_o | output | 1 | A pass is in progress |
| pending_o | output | 8 | Pending mask |
| fault_flags_o | output | 8 | Per-element fault flags of the latest pass |
| done_o | output | 1 | Fault-free pass finished (one cycle) |
| exc_o | output | 1 | Deferred fault exception (one cycle) |

## Verification
The assertions assume that the translation responder raises `xlat_valid_i` only while an element is waiting, for one cycle per request. The bench's responder follows this: it answers each observed request exactly once, one cycle later, and drives nothing in between. The assertions also assume that `len_i` lies in 1 to 8 when a start is accepted. Every scenario uses lengths in that range, and the bench changes configuration inputs only at falling edges, so every start is sampled cleanly.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    parameter int VFD_VLEN = 8;
    parameter int VFD_AW   = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } vfd_state_e;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } vfd_priv_e;

    typedef struct packed {
        logic valid;
        logic fault;
    } vfd_rsp_t;

    typedef struct packed {
        logic indexed;
        logic store;
    } vfd_mode_t;

    function automatic logic vfd_priv_ok(input logic [1:0] p);
        return (p == PRIV_SUPER) || (p == PRIV_MACH);
    endfunction

endpackage

// File: rtl/vfd_addr_gen.sv
module vfd_addr_gen
    import vfd_pkg::*;
#(
    parameter int VLEN       = VFD_VLEN,
    parameter int AW         = VFD_AW,
    parameter int ELEM_BYTES = 4,
    localparam int IW        = (VLEN > 1) ? $clog2(VLEN) : 1
) (
    input  logic                 indexed_i,
    input  logic [AW-1:0]        base_i,
    input  logic [VLEN*AW-1:0]   index_i,
    input  logic [IW-1:0]        elem_i,
    output logic [AW-1:0]        addr_o
);
    logic [AW-1:0] offs [VLEN];

    for (genvar g = 0; g < VLEN; g++) begin : g_offs
        localparam logic [AW-1:0] STRIDE_OFF = AW'(g * ELEM_BYTES);
        assign offs[g] = indexed_i ? index_i[g*AW +: AW] : STRIDE_OFF;
    end

    always_comb begin
        addr_o = base_i + offs[elem_i];
    end
endmodule

// File: rtl/vfd_fault_store.sv
module vfd_fault_store
    import vfd_pkg::*;
#(
    parameter int VLEN = VFD_VLEN,
    parameter int AW   = VFD_AW,
    localparam int IW  = (VLEN > 1) ? $clog2(VLEN) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                rec_fault_i,
    input  logic                rec_ok_i,
    input  logic [IW-1:0]       elem_i,
    input  logic [AW-1:0]       addr_i,
    input  logic                rd_en_i,
    input  logic [1:0]          rd_priv_i,
    input  logic [IW-1:0]       rd_idx_i,
    output logic [AW-1:0]       rd_data_o,
    output logic                rd_err_o,
    output logic [VLEN-1:0]     flags_o
);
    logic [VLEN-1:0] flags_q;
    logic [AW-1:0]   addr_q [VLEN];
    logic            allowed;

    assign allowed = vfd_priv_ok(rd_priv_i);

    for (genvar g = 0; g < VLEN; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                flags_q[g] <= 1'b0;
                addr_q[g]  <= '0;
            end else if (rec_fault_i && elem_i == IW'(g)) begin
                flags_q[g] <= 1'b1;
                addr_q[g]  <= addr_i;
            end else if (rec_ok_i && elem_i == IW'(g)) begin
                flags_q[g] <= 1'b0;
                addr_q[g]  <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o <= '0;
            rd_err_o  <= 1'b0;
        end else begin
            rd_data_o <= (rd_en_i && allowed) ? addr_q[rd_idx_i] : '0;
            rd_err_o  <= rd_en_i && !allowed;
        end
    end

    assign flags_o = flags_q;

    // R6: a rejected read never carries data
    p_reject_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rd_err_o |-> (rd_data_o == '0));

    // R6: rejection lasts one cycle per strobe
    p_reject_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_err_o && !$past(rd_en_i)) |-> 1'b0);
endmodule

// File: rtl/vfd_seq_ctrl.sv
module vfd_seq_ctrl
    import vfd_pkg::*;
#(
    parameter int VLEN = VFD_VLEN,
    localparam int IW  = (VLEN > 1) ? $clog2(VLEN) : 1,
    localparam int CW  = $clog2(VLEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              restart_i,
    input  logic [CW-1:0]     len_i,
    input  vfd_rsp_t          rsp_i,
    input  logic              any_fault_i,
    output logic              accept_o,
    output logic              mreq_valid_o,
    output logic [IW-1:0]     elem_o,
    output logic              rec_fault_o,
    output logic              rec_ok_o,
    output logic [VLEN-1:0]   pending_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              exc_o
);
    vfd_state_e      st_q;
    logic [CW-1:0]   cur_q;
    logic [VLEN-1:0] pend_q;
    logic [VLEN-1:0] len_mask;
    logic            at_end;
    logic            cur_pend;

    for (genvar g = 0; g < VLEN; g++) begin : g_lmask
        assign len_mask[g] = (CW'(g) < len_i);
    end

    assign at_end       = (cur_q >= CW'(VLEN));
    assign elem_o       = cur_q[IW-1:0];
    assign cur_pend     = !at_end && pend_q[elem_o];
    assign accept_o     = (st_q == ST_IDLE) && start_i;
    assign mreq_valid_o = (st_q == ST_ISSUE) && cur_pend;
    assign rec_fault_o  = (st_q == ST_WAIT) && rsp_i.valid && rsp_i.fault;
    assign rec_ok_o     = (st_q == ST_WAIT) && rsp_i.valid && !rsp_i.fault;
    assign done_o       = (st_q == ST_FINISH) && !any_fault_i;
    assign exc_o        = (st_q == ST_FINISH) && any_fault_i;
    assign busy_o       = (st_q != ST_IDLE);
    assign pending_o    = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            pend_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        pend_q <= restart_i ? (pend_q & len_mask) : len_mask;
                        cur_q  <= '0;
                        st_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (at_end) begin
                        st_q <= ST_FINISH;
                    end else if (cur_pend) begin
                        st_q <= ST_WAIT;
                    end else begin
                        cur_q <= cur_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (rsp_i.valid) begin
                        if (!rsp_i.fault) begin
                            pend_q[elem_o] <= 1'b0;
                        end
                        cur_q <= cur_q + 1'b1;
                        st_q  <= ST_ISSUE;
                    end
                end
                ST_FINISH: begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R7: never two requests back to back; each waits for its response
    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
        mreq_valid_o |=> !mreq_valid_o);

    // R1: a recorded fault is followed by further walking, not a trap
    p_defer_trap_r1: assert property (@(posedge clk) disable iff (rst)
        rec_fault_o |=> !exc_o);

    // R2: exception and done never coincide
    p_single_outcome_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_o, done_o}));
endmodule

// File: rtl/vfd_seq_top.sv
module vfd_seq_top
    import vfd_pkg::*;
#(
    parameter int VLEN       = VFD_VLEN,
    parameter int AW         = VFD_AW,
    parameter int ELEM_BYTES = 4,
    localparam int IW        = (VLEN > 1) ? $clog2(VLEN) : 1,
    localparam int CW        = $clog2(VLEN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                restart_i,
    input  logic                indexed_i,
    input  logic                store_i,
    input  logic [CW-1:0]       len_i,
    input  logic [AW-1:0]       base_i,
    input  logic [VLEN*AW-1:0]  index_i,
    output logic                mreq_valid_o,
    output logic                mreq_store_o,
    output logic [IW-1:0]       mreq_elem_o,
    output logic [AW-1:0]       mreq_addr_o,
    input  logic                xlat_valid_i,
    input  logic                xlat_fault_i,
    input  logic                rd_en_i,
    input  logic [1:0]          rd_priv_i,
    input  logic [IW-1:0]       rd_idx_i,
    output logic [AW-1:0]       rd_data_o,
    output logic                rd_err_o,
    output logic                busy_o,
    output logic [VLEN-1:0]     pending_o,
    output logic [VLEN-1:0]     fault_flags_o,
    output logic                done_o,
    output logic                exc_o
);
    vfd_mode_t          mode_q;
    logic [AW-1:0]      base_q;
    logic [VLEN*AW-1:0] index_q;
    vfd_rsp_t           rsp;
    logic               accept;
    logic               rec_fault;
    logic               rec_ok;
    logic [IW-1:0]      elem;
    logic [AW-1:0]      elem_addr;
    logic [VLEN-1:0]    flags;

    assign rsp.valid = xlat_valid_i;
    assign rsp.fault = xlat_fault_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            base_q  <= '0;
            index_q <= '0;
        end else if (accept) begin
            mode_q.indexed <= indexed_i;
            mode_q.store   <= store_i;
            base_q         <= base_i;
            index_q        <= index_i;
        end
    end

    vfd_seq_ctrl #(.VLEN(VLEN)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .restart_i    (restart_i),
        .len_i        (len_i),
        .rsp_i        (rsp),
        .any_fault_i  (|flags),
        .accept_o     (accept),
        .mreq_valid_o (mreq_valid_o),
        .elem_o       (elem),
        .rec_fault_o  (rec_fault),
        .rec_ok_o     (rec_ok),
        .pending_o    (pending_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .exc_o        (exc_o)
    );

    vfd_addr_gen #(.VLEN(VLEN), .AW(AW), .ELEM_BYTES(ELEM_BYTES)) u_agen (
        .indexed_i (mode_q.indexed),
        .base_i    (base_q),
        .index_i   (index_q),
        .elem_i    (elem),
        .addr_o    (elem_addr)
    );

    vfd_fault_store #(.VLEN(VLEN), .AW(AW)) u_store (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (accept),
        .rec_fault_i (rec_fault),
        .rec_ok_i    (rec_ok),
        .elem_i      (elem),
        .addr_i      (elem_addr),
        .rd_en_i     (rd_en_i),
        .rd_priv_i   (rd_priv_i),
        .rd_idx_i    (rd_idx_i),
        .rd_data_o   (rd_data_o),
        .rd_err_o    (rd_err_o),
        .flags_o     (flags)
    );

    assign mreq_store_o  = mode_q.store;
    assign mreq_elem_o   = elem;
    assign mreq_addr_o   = elem_addr;
    assign fault_flags_o = flags;

    // R3: a request only targets an element still marked pending
    p_only_pending_r3: assert property (@(posedge clk) disable iff (rst)
        mreq_valid_o |-> pending_o[mreq_elem_o]);

    // R2: the exception needs at least one recorded fault
    p_exc_has_fault_r2: assert property (@(posedge clk) disable iff (rst)
        exc_o |-> (fault_flags_o != '0));

    // R9: a clean finish leaves nothing pending
    p_done_clean_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pending_o == '0 && fault_flags_o == '0));

    // R10: a start while busy does not disturb the pass
    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(base_q));
endmodule

// File: tb/vfd_seq_top_tb_top.sv
module vfd_seq_top_tb_top;
    localparam int VLEN = 8;
    localparam int AW   = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            start_i, restart_i, indexed_i, store_i;
    logic [3:0]      len_i;
    logic [AW-1:0]   base_i;
    logic [VLEN*AW-1:0] index_i;
    logic            mreq_valid_o, mreq_store_o;
    logic [2:0]      mreq_elem_o;
    logic [AW-1:0]   mreq_addr_o;
    logic            xlat_valid_i, xlat_fault_i;
    logic            rd_en_i;
    logic [1:0]      rd_priv_i;
    logic [2:0]      rd_idx_i;
    logic [AW-1:0]   rd_data_o;
    logic            rd_err_o, busy_o, done_o, exc_o;
    logic [VLEN-1:0] pending_o, fault_flags_o;

    int errors = 0;
    int checks = 0;

    logic [VLEN-1:0] fault_plan;
    int              issue_cnt [VLEN];
    logic [AW-1:0]   issue_addr [VLEN];
    int              issue_total;
    logic            armed;
    logic [2:0]      armed_elem;

    always #5 clk = ~clk;

    vfd_seq_top dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .restart_i(restart_i),
        .indexed_i(indexed_i), .store_i(store_i), .len_i(len_i),
        .base_i(base_i), .index_i(index_i),
        .mreq_valid_o(mreq_valid_o), .mreq_store_o(mreq_store_o),
        .mreq_elem_o(mreq_elem_o), .mreq_addr_o(mreq_addr_o),
        .xlat_valid_i(xlat_valid_i), .xlat_fault_i(xlat_fault_i),
        .rd_en_i(rd_en_i), .rd_priv_i(rd_priv_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .rd_err_o(rd_err_o), .busy_o(busy_o),
        .pending_o(pending_o), .fault_flags_o(fault_flags_o),
        .done_o(done_o), .exc_o(exc_o)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Translation responder: answers each request one cycle later, once.
    initial begin
        xlat_valid_i = 1'b0;
        xlat_fault_i = 1'b0;
        armed = 1'b0;
        armed_elem = '0;
        forever begin
            @(negedge clk);
            xlat_valid_i = 1'b0;
            xlat_fault_i = 1'b0;
            if (armed) begin
                xlat_valid_i = 1'b1;
                xlat_fault_i = fault_plan[armed_elem];
                armed = 1'b0;
            end else if (mreq_valid_o && !rst) begin
                issue_cnt[mreq_elem_o]++;
                issue_addr[mreq_elem_o] = mreq_addr_o;
                issue_total++;
                armed_elem = mreq_elem_o;
                armed = 1'b1;
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic clear_log();
        for (int i = 0; i < VLEN; i++) begin
            issue_cnt[i] = 0;
            issue_addr[i] = '0;
        end
        issue_total = 0;
    endtask

    // Runs one pass; optionally tries a second start mid-pass.
    task automatic run_pass(input logic rs, input logic ix, input logic [3:0] ln,
                            input logic [AW-1:0] bs, input logic poke,
                            output logic saw_done, output logic saw_exc,
                            output int total_at_exc, output int pulses);
        clear_log();
        saw_done = 0; saw_exc = 0; total_at_exc = -1; pulses = 0;
        @(negedge clk);
        restart_i = rs; indexed_i = ix; len_i = ln; base_i = bs; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (poke && c == 3) begin
                base_i = bs + 32'h0100_0000;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin saw_done = 1; pulses++; end
            if (exc_o) begin saw_exc = 1; pulses++; total_at_exc = issue_total; end
            if (!busy_o && c > 0 && !start_i) break;
            @(negedge clk);
        end
        start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] pv, input logic [2:0] ix,
                           output logic [AW-1:0] data, output logic err,
                           output logic err_after);
        @(negedge clk);
        rd_en_i = 1'b1; rd_priv_i = pv; rd_idx_i = ix;
        @(negedge clk);
        rd_en_i = 1'b0;
        data = rd_data_o;
        err = rd_err_o;
        @(negedge clk);
        err_after = rd_err_o;
    endtask

    function automatic logic [AW-1:0] idx_val(input int i);
        return 32'h0000_3000 * i + 32'h0000_0040 * (i + 1);
    endfunction

    localparam logic [AW-1:0] BASE_A = 32'h4000_0000;
    localparam logic [AW-1:0] BASE_B = 32'h1234_0000;

    task automatic t_reset();
        chk(busy_o == 0, "R3 reset busy", 32'(busy_o), 0);
        chk(pending_o == 0, "R3 reset pending", 32'(pending_o), 0);
        chk(!done_o && !exc_o, "R2 reset outputs", {30'b0, done_o, exc_o}, 0);
    endtask

    task automatic t_unit_clean();
        logic d, e; int t, p; logic [AW-1:0] rd; logic er, ea;
        fault_plan = '0;
        run_pass(0, 0, 4'd8, BASE_A, 0, d, e, t, p);
        chk(d && !e, "R9 done without exc", {30'b0, d, e}, 32'h2);
        chk(p == 1, "R2 one-cycle outcome", 32'(p), 1);
        chk(pending_o == 0, "R9 pending cleared", 32'(pending_o), 0);
        for (int i = 0; i < VLEN; i++) begin
            chk(issue_cnt[i] == 1, "R3 each element once", 32'(issue_cnt[i]), 1);
            chk(issue_addr[i] == BASE_A + 32'(4 * i), "R7 unit-stride address",
                issue_addr[i], BASE_A + 32'(4 * i));
        end
        do_read(2'b01, 3'd4, rd, er, ea);
        chk(rd == 0 && !er, "R9 array zero after clean pass", rd, 0);
    endtask

    task automatic t_indexed_faults();
        logic d, e; int t, p; logic [AW-1:0] rd; logic er, ea;
        for (int i = 0; i < VLEN; i++) index_i[i*AW +: AW] = idx_val(i);
        fault_plan = 8'b0010_0100;
        run_pass(0, 1, 4'd8, BASE_B, 0, d, e, t, p);
        chk(e && !d, "R2 exception raised", {30'b0, d, e}, 32'h1);
        chk(t == 8, "R1 all elements attempted before exc", 32'(t), 8);
        chk(p == 1, "R2 exception one cycle", 32'(p), 1);
        chk(fault_flags_o == 8'h24, "R1 fault flags", 32'(fault_flags_o), 32'h24);
        chk(pending_o == 8'h24, "R3 faulted stay pending", 32'(pending_o), 32'h24);
        for (int i = 0; i < VLEN; i++)
            chk(issue_addr[i] == BASE_B + idx_val(i), "R7 indexed address",
                issue_addr[i], BASE_B + idx_val(i));
        do_read(2'b01, 3'd2, rd, er, ea);
        chk(rd == BASE_B + idx_val(2) && !er, "R5 fault address elem 2 (supervisor)",
            rd, BASE_B + idx_val(2));
        do_read(2'b11, 3'd5, rd, er, ea);
        chk(rd == BASE_B + idx_val(5) && !er, "R6 machine read elem 5",
            rd, BASE_B + idx_val(5));
        do_read(2'b01, 3'd0, rd, er, ea);
        chk(rd == 0, "R5 non-faulted entry zero", rd, 0);
        do_read(2'b00, 3'd2, rd, er, ea);
        chk(rd == 0, "R6 user read data zero", rd, 0);
        chk(er == 1, "R6 user read error flag", 32'(er), 1);
        chk(ea == 0, "R6 error flag one cycle", 32'(ea), 0);
    endtask

    task automatic t_restart();
        logic d, e; int t, p; logic [AW-1:0] rd; logic er, ea;
        fault_plan = '0;
        run_pass(1, 1, 4'd8, BASE_B, 0, d, e, t, p);
        chk(d && !e, "R4 restart completes", {30'b0, d, e}, 32'h2);
        for (int i = 0; i < VLEN; i++) begin
            int ex = (i == 2 || i == 5) ? 1 : 0;
            chk(issue_cnt[i] == ex, "R4 completed elements skipped",
                32'(issue_cnt[i]), 32'(ex));
        end
        chk(pending_o == 0 && fault_flags_o == 0, "R9 restart clean",
            {16'b0, pending_o, fault_flags_o}, 0);
        do_read(2'b01, 3'd2, rd, er, ea);
        chk(rd == 0, "R5 entry cleared after restart", rd, 0);
    endtask

    task automatic t_short_len();
        logic d, e; int t, p;
        fault_plan = 8'b0100_0000;
        run_pass(0, 0, 4'd3, BASE_A, 0, d, e, t, p);
        chk(d && !e, "R8 short pass done", {30'b0, d, e}, 32'h2);
        chk(issue_total == 3, "R8 only active elements issued", 32'(issue_total), 3);
        chk(pending_o == 0, "R8 inactive not pending", 32'(pending_o), 0);
    endtask

    task automatic t_busy_start();
        logic d, e; int t, p;
        fault_plan = '0;
        run_pass(0, 0, 4'd8, BASE_A, 1, d, e, t, p);
        chk(d && p == 1, "R10 single outcome", 32'(p), 1);
        chk(issue_total == 8, "R10 no extra requests", 32'(issue_total), 8);
        chk(issue_addr[7] == BASE_A + 32'd28, "R10 config kept",
            issue_addr[7], BASE_A + 32'd28);
        chk(busy_o == 0, "R10 idle after pass", 32'(busy_o), 0);
    endtask

    initial begin
        rst = 1'b1;
        start_i = 0; restart_i = 0; indexed_i = 0; store_i = 0;
        len_i = 4'd8; base_i = '0; index_i = '0;
        rd_en_i = 0; rd_priv_i = 2'b00; rd_idx_i = '0;
        fault_plan = '0;
        clear_log();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unit_clean();
        t_indexed_faults();
        t_restart();
        t_short_len();
        t_busy_start();
        summary();
        $finish;
    end
endmodule